// File: doc/BRIEF.md
# Receive interrupt status controller

The block gathers single-cycle event pulses from an HDLC receiver into a sticky six-bit interrupt status register. It drives an active-high interrupt output whenever a status bit is set and that bit is enabled in a software mask. Every event is recorded whether or not it is masked. The mask only decides which recorded events may raise the interrupt. A status bit records that an event happened. It does not say whether the underlying condition still holds.

One bit position is shared. A select input decides whether that bit reports a receive frame abort or a transmit underrun.

Clearing is tied to a serial microport read of the status address. The microport shifter decodes the command/address byte and raises a read-command level. The block synchronises that level and the serial clock into the system clock domain. On the first falling serial-clock edge after the command, the block captures the status register into a read snapshot and drops the interrupt.

While that read cycle is open, new events are deferred rather than lost. An event for a bit that is already set is absorbed, because the snapshot already reports it. When the command level falls, the status register is cleared and the deferred events are posted. If any posted event is masked in, the interrupt asserts again.

Top module: `rx_irq_ctrl`

## Requirements
- R1: Each event pulse sets its status bit regardless of the mask. Bit positions are: [0] go-ahead, [1] end-of-packet detected, [2] end-of-packet read, [3] shared abort/underrun, [4] FIFO filling, [5] FIFO overflow.
- R2: Outside a read cycle, `irq` is high exactly when some status bit is set and the matching `irq_mask` bit is 1. A change of the mask takes effect in the same cycle.
- R3: A set status bit stays set, and `irq` stays high, until a completed read of the status register.
- R4: With `sel_tx` = 0, bit 3 is set only by `rx_evt[3]` (frame abort), and `tx_underrun` has no effect. With `sel_tx` = 1, bit 3 is set only by `tx_underrun`, and `rx_evt[3]` has no effect.
- R5: After `rd_cmd` rises, `irq` stays high until the first falling edge of `sclk`. It is low no more than 4 system clock cycles after that edge, and it remains low while the read cycle is open.
- R6: At that serial clock falling edge, `rd_data` captures the status register and `rd_valid` pulses for one cycle. `rd_data` holds the captured value until the next read.
- R7: When `rd_cmd` falls after such an edge, the status register is cleared. Events that arrived during the read for bits not already set are then posted, and they raise `irq` again if they are masked in.
- R8: An event that arrives during a read for a bit that is already set is absorbed. After the read, that bit is clear.
- R9: An event that arrives in the same cycle that ends a read is kept, because setting has priority over clearing.
- R10: If `rd_cmd` rises and falls with no falling `sclk` edge in between, the status register is not cleared.
- R11: During reset the status register, `rd_data`, `rd_valid` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_evt | input | 6 | Receive event pulses, one per status bit |
| tx_underrun | input | 1 | Transmit underrun pulse, shares bit 3 |
| sel_tx | input | 1 | Selects the bit 3 source: 0 frame abort, 1 underrun |
| irq_mask | input | 6 | Interrupt enable per status bit |
| sclk | input | 1 | Serial microport clock, idle high, asynchronous |
| rd_cmd | input | 1 | Level from the shifter: a read of the status address has been decoded |
| rd_data | output | 6 | Status snapshot taken at the start of the read |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is updated |
| irq | output | 1 | Active-high interrupt request |

## Verification
Four rules are checked on every cycle:
- Status bits are sticky outside a read.
- An unmasked-or-masked event outside a read lands in its bit.
- The register is frozen while a read window is open.
- The snapshot equals the register at the capture edge, and the interrupt is low right after capture.

Some behaviour can only be shown by the bench's scenarios:
- Deferred events being posted after the clear.
- An already-set bit being absorbed.
- An event in the closing cycle surviving.
- Both settings of the shared-bit select.
- A withdrawn command leaving the register untouched.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;
  localparam int NUM_EVT    = 6;
  localparam int IDX_GO     = 0;
  localparam int IDX_EOPD   = 1;
  localparam int IDX_EOPR   = 2;
  localparam int IDX_SHARED = 3;
  localparam int IDX_FILL   = 4;
  localparam int IDX_OVFL   = 5;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_ARMED = 2'd1,
    RD_BUSY  = 2'd2
  } rd_state_t;
endpackage

// File: rtl/irq_evt_mux.sv
module irq_evt_mux #(
  parameter int N_EVT      = 6,
  parameter int SHARED_IDX = 3
) (
  input  logic [N_EVT-1:0] rx_evt,
  input  logic             tx_evt,
  input  logic             sel_tx,
  output logic [N_EVT-1:0] ev_eff
);
  // One bit position carries either the receive or the transmit source.
  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    if (i == SHARED_IDX) begin : g_shared
      assign ev_eff[i] = sel_tx ? tx_evt : rx_evt[i];
    end else begin : g_plain
      assign ev_eff[i] = rx_evt[i];
    end
  end
endmodule

// File: rtl/irq_rd_seq.sv
module irq_rd_seq
  import rx_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic rd_cmd,
  output logic snap,
  output logic busy,
  output logic done
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sck_sr;
  logic [LAST:0] cmd_sr;
  logic          sck_prev;
  logic          sck_s;
  logic          cmd_s;
  logic          fall;
  rd_state_t     st_q;
  rd_state_t     st_d;

  // Synchronise the serial clock and the command level into clk.
  // The serial clock idles high, so its chain resets to all ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sr   <= '1;
      cmd_sr   <= '0;
      sck_prev <= 1'b1;
    end else begin
      sck_sr   <= {sck_sr[LAST-1:0], sclk};
      cmd_sr   <= {cmd_sr[LAST-1:0], rd_cmd};
      sck_prev <= sck_s;
    end
  end

  assign sck_s = sck_sr[LAST];
  assign cmd_s = cmd_sr[LAST];
  assign fall  = sck_prev & ~sck_s;

  // IDLE -> ARMED when a read command is seen.
  // ARMED -> BUSY on the first serial clock fall; back to IDLE if withdrawn.
  // BUSY -> IDLE when the command level drops.
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RD_IDLE:  if (cmd_s) st_d = RD_ARMED;
      RD_ARMED: if (!cmd_s) st_d = RD_IDLE;
                else if (fall) st_d = RD_BUSY;
      RD_BUSY:  if (!cmd_s) st_d = RD_IDLE;
      default:  st_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RD_IDLE;
    else        st_q <= st_d;
  end

  assign snap = (st_q == RD_ARMED) & cmd_s & fall;
  assign busy = (st_q == RD_BUSY);
  assign done = busy & ~cmd_s;
endmodule

// File: rtl/irq_stat_core.sv
module irq_stat_core #(
  parameter int N_EVT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] ev,
  input  logic             snap,
  input  logic             busy,
  input  logic             done,
  output logic [N_EVT-1:0] st_q,
  output logic [N_EVT-1:0] hold_q,
  output logic [N_EVT-1:0] rd_data,
  output logic             rd_valid
);
  logic win;

  assign win = snap | busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      hold_q <= '0;
    end else if (done) begin
      // Clear, but new events this cycle win over the clear.
      st_q   <= hold_q | ev;
      hold_q <= '0;
    end else if (win) begin
      // Defer only the events whose bit is not already reported.
      hold_q <= hold_q | (ev & ~st_q);
    end else begin
      st_q   <= st_q | ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= snap;
      if (snap) rd_data <= st_q;
    end
  end
endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
  import rx_irq_pkg::*;
#(
  parameter int N_EVT       = NUM_EVT,
  parameter int SHARED_IDX  = IDX_SHARED,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] rx_evt,
  input  logic             tx_underrun,
  input  logic             sel_tx,
  input  logic [N_EVT-1:0] irq_mask,
  input  logic             sclk,
  input  logic             rd_cmd,
  output logic [N_EVT-1:0] rd_data,
  output logic             rd_valid,
  output logic             irq
);
  logic [N_EVT-1:0] ev_eff;
  logic [N_EVT-1:0] st_q;
  logic [N_EVT-1:0] hold_q;
  logic             snap;
  logic             busy;
  logic             done;

  irq_evt_mux #(.N_EVT(N_EVT), .SHARED_IDX(SHARED_IDX)) u_mux (
    .rx_evt (rx_evt),
    .tx_evt (tx_underrun),
    .sel_tx (sel_tx),
    .ev_eff (ev_eff)
  );

  irq_rd_seq #(.SYNC_STAGES(SYNC_STAGES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk   (sclk),
    .rd_cmd (rd_cmd),
    .snap   (snap),
    .busy   (busy),
    .done   (done)
  );

  irq_stat_core #(.N_EVT(N_EVT)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev_eff),
    .snap     (snap),
    .busy     (busy),
    .done     (done),
    .st_q     (st_q),
    .hold_q   (hold_q),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign irq = (|(st_q & irq_mask)) & ~busy;
endmodule

// File: rtl/rx_irq_ctrl_chk.sv
module rx_irq_ctrl_chk #(
  parameter int N_EVT = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [N_EVT-1:0] rd_data,
  input logic [N_EVT-1:0] st_q,
  input logic [N_EVT-1:0] ev_eff,
  input logic             snap,
  input logic             busy,
  input logic             done
);
  // R3
  sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ((st_q & $past(st_q)) == $past(st_q)));

  // R1
  event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap && !busy) |=> ((st_q & $past(ev_eff)) == $past(ev_eff)));

  // R7
  frozen_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((snap || busy) && !done) |=> $stable(st_q));

  // R6
  snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (rd_data == $past(st_q)));

  // R5
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> !irq);
endmodule

bind rx_irq_ctrl rx_irq_ctrl_chk #(.N_EVT(N_EVT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .rd_data (rd_data),
  .st_q    (st_q),
  .ev_eff  (ev_eff),
  .snap    (snap),
  .busy    (busy),
  .done    (done)
);

// File: tb/rx_irq_ctrl_bench.sv
module rx_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] rx_evt = '0;
  logic       tx_underrun = 1'b0;
  logic       sel_tx = 1'b0;
  logic [5:0] irq_mask = '0;
  logic       sclk = 1'b1;
  logic       rd_cmd = 1'b0;
  logic [5:0] rd_data;
  logic       rd_valid;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [5:0] exp_q[$];

  always #2 clk = ~clk;

  rx_irq_ctrl u_rx_irq_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_evt      (rx_evt),
    .tx_underrun (tx_underrun),
    .sel_tx      (sel_tx),
    .irq_mask    (irq_mask),
    .sclk        (sclk),
    .rd_cmd      (rd_cmd),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .irq         (irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic [5:0] rx, logic tx);
    @(negedge clk);
    rx_evt = rx;
    tx_underrun = tx;
    @(negedge clk);
    rx_evt = '0;
    tx_underrun = 1'b0;
  endtask

  task automatic rd_open(logic [5:0] exp);
    exp_q.push_back(exp);
    @(negedge clk);
    rd_cmd = 1'b1;
    wait_n(4);
    sclk = 1'b0;
    wait_n(4);
  endtask

  task automatic rd_close();
    @(negedge clk);
    rd_cmd = 1'b0;
    sclk = 1'b1;
    wait_n(4);
  endtask

  task automatic do_read(logic [5:0] exp);
    rd_open(exp);
    rd_close();
  endtask

  // Monitor: scoreboard for the read snapshot (R6).
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected snapshot", 32'd1, 32'd0);
      end else begin
        automatic logic [5:0] e = exp_q.pop_front();
        check("R6 snapshot", rd_data, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_n(3);
    // R11 reset state
    check("R11 irq", irq, 0);
    check("R11 rd_data", rd_data, 0);
    check("R11 rd_valid", rd_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_n(2);

    // R1 / R2: all events with mask off
    pulse(6'h3F, 1'b0);
    check("R2 masked irq low", irq, 0);
    irq_mask = 6'h3F;
    #0;
    check("R2 mask enables irq", irq, 1);
    irq_mask = 6'h00;
    do_read(6'h3F);          // R1 all bits recorded
    do_read(6'h00);          // R7 cleared after read

    // R3 / R5 / R7 / R8
    irq_mask = 6'h02;
    pulse(6'h02, 1'b0);
    check("R2 masked-in irq", irq, 1);
    wait_n(10);
    check("R3 sticky irq", irq, 1);
    exp_q.push_back(6'h02);
    @(negedge clk);
    rd_cmd = 1'b1;
    wait_n(6);
    check("R5 irq before sclk fall", irq, 1);
    sclk = 1'b0;
    wait_n(4);
    check("R5 irq low after fall", irq, 0);
    pulse(6'h02, 1'b0);      // R8 absorbed
    pulse(6'h10, 1'b0);      // R7 deferred
    irq_mask = 6'h12;
    #0;
    check("R5 irq low during read", irq, 0);
    rd_close();
    check("R7 irq reasserts", irq, 1);
    do_read(6'h10);          // R7 posted, R8 bit1 gone
    check("R7 irq low after clear", irq, 0);

    // R4 shared bit
    irq_mask = 6'h08;
    sel_tx = 1'b1;
    pulse(6'h08, 1'b0);
    check("R4 abort ignored when sel_tx=1", irq, 0);
    pulse(6'h00, 1'b1);
    check("R4 underrun sets bit3", irq, 1);
    do_read(6'h08);
    sel_tx = 1'b0;
    pulse(6'h00, 1'b1);
    check("R4 underrun ignored when sel_tx=0", irq, 0);
    pulse(6'h08, 1'b0);
    check("R4 abort sets bit3", irq, 1);
    do_read(6'h08);

    // R10 withdrawn command
    irq_mask = 6'h01;
    pulse(6'h01, 1'b0);
    @(negedge clk);
    rd_cmd = 1'b1;
    wait_n(8);
    rd_cmd = 1'b0;
    wait_n(4);
    check("R10 no clear without sclk fall", irq, 1);
    do_read(6'h01);

    // R9 event in the closing cycle
    irq_mask = 6'h20;
    rd_open(6'h00);
    @(negedge clk);
    rd_cmd = 1'b0;
    sclk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rx_evt = 6'h20;
    @(negedge clk);
    rx_evt = '0;
    wait_n(2);
    check("R9 event kept at read end", irq, 1);
    do_read(6'h20);

    wait_n(2);
    check("R6 all snapshots seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule